// File: doc/BRIEF.md
# Inline Encryption Keyslot Register File

This block is the register file that holds the per-slot cipher configurations of a storage host controller's inline encryption engine. Software reaches it through a simple 32-bit register bus with separate write and read strobes. Reads return data one cycle after the strobe. The block holds three kinds of state. A read-only capability word describes how many slots and capability entries exist and where the slot array sits. A read-only array of capability entries lists the cipher and unit-size combinations the engine offers. The slot array holds, for each slot, sixteen key words, a control word and a spare configuration word. The control word carries an enable flag, a capability index and a one-hot data-unit-size mask.

The cipher datapath selects a slot by index. It receives that slot's key, unit-size mask and capability index only when the slot holds a committed, well-formed configuration. A slot becomes committed only through a fixed programming order. First the control word is written with enable clear, which also wipes the key. Then the key words are written in ascending order, then the spare word, and the control word last with enable set. Any departure from that order leaves the slot unusable until it is reprogrammed. Writing zero to all of a slot's words, in any order, evicts it.

Top module: `inline_keyslot_regs`

## Requirements
- R1: After reset every slot word reads zero and no slot is valid.
- R2: The capability word reads at byte address 0x100 as {array pointer [31:24], zero [23:16], slot count minus one [15:8], capability count [7:0]}. Writes to it have no effect.
- R3: Capability entry i reads at 0x104 + 4*i as {zero [31:24], key-size code 0x03 [23:16], unit-size mask 0xFF >> i [15:8], algorithm code i+1 [7:0]}. Addresses past the last entry read zero.
- R4: Slot s starts at byte address array pointer * 0x100 + s * 0x80, and word d of it sits at +4*d. Key words are d = 0..15, the control word is d = 16 and the spare word is d = 17. Every stored word reads back one cycle after the read strobe, and the two low address bits are ignored.
- R5: A slot turns valid only when it sees this write order: control word with bit 31 clear, key words 0 to 15 ascending, spare word, then control word with bit 31 set. A valid slot selected on the datapath index presents its key (word k at bits 32k+31:32k), its unit mask (control bits 7:0) and its capability index (control bits 15:8). For an invalid slot these outputs are all zero.
- R6: While a slot's control bit 31 is set, writes to its key words or spare word are ignored, and its valid state is unchanged.
- R7: If key words arrive out of order, or the spare word is skipped, the final enabling control write leaves the slot invalid. The written words are still stored.
- R8: The commit also needs three things: exactly one bit set in the unit mask, a capability index below the capability count, and the unit mask overlapping that capability's unit-size mask. Mask bit 7 (65536-byte units) is a legal boundary value.
- R9: A control write with bit 31 clear drops the slot's valid state and zeroes its key words. Zero writes to all 18 words of a slot, in ascending order, leave it reading all zero and invalid.
- R10: Writing the control word with bit 31 set again, without a fresh sequence, makes the slot invalid.
- R11: Writes to a slot index at or beyond the slot count, to words 18 to 31 of a slot, or to unmapped addresses are dropped and do not alias onto a real slot. Reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| slot_valid | output | NUM_SLOTS | Per-slot committed configuration flag |
| dp_slot | input | SLOT_W | Slot index chosen by the datapath |
| dp_valid | output | 1 | Chosen slot holds a committed configuration |
| dp_key | output | 512 | Key words of the chosen slot |
| dp_unit_mask | output | 8 | One-hot data-unit-size mask of the chosen slot |
| dp_cap_idx | output | 8 | Capability index of the chosen slot |

## Verification
A small configuration with four slots and three capability entries is swept. Every slot is programmed with the correct order and distinct key patterns, and the full readback and datapath lookup show that slot decoding and key word placement are right. Broken orders are then applied to single slots while the other slots stay valid: keys swapped, spare word skipped, re-enable without a fresh sequence, and key writes to an enabled slot. These separate the sequence tracker from plain storage. Malformed control fields and the 65536-byte boundary test the commit checks. Writes to indices 4 to 7 and past the slot window would land on real slots if an index bit were dropped, so they show whether decoding aliases.

// File: rtl/keyslot_pkg.sv
// Shared constants and helpers for the keyslot register file.
// Assumes 32-bit registers and an 18-word slot entry placed on a 128-byte stride.
package keyslot_pkg;
    localparam int          DW          = 32;
    localparam int          KEY_WORDS   = 16;
    localparam int          KEY_BITS    = KEY_WORDS * DW;
    localparam int          DWORD_SEL_W = 5;
    localparam int          SLOT_WORDS  = 18;
    localparam int          STRIDE_LOG2 = 7;
    localparam logic [4:0]  CTRL_DWORD  = 5'd16;
    localparam logic [4:0]  SPARE_DWORD = 5'd17;
    localparam int          EN_BIT      = 31;

    // Unit-size mask advertised by capability entry idx.
    function automatic logic [7:0] cap_unit_mask(input logic [7:0] idx);
        return 8'hFF >> idx;
    endfunction

    // Full capability entry word for index idx.
    function automatic logic [31:0] cap_entry(input logic [7:0] idx);
        return {8'h00, 8'h03, cap_unit_mask(idx), idx + 8'd1};
    endfunction
endpackage

// File: rtl/keyslot_addr_decode.sv
// Decodes a byte address into slot-window coordinates.
// The window spans 2^(clog2(NUM_SLOTS)+1) slots so that out-of-range indices are
// recognised rather than aliased. Assumes the window fits within ADDR_W bits.
module keyslot_addr_decode
    import keyslot_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int ARRAY_PTR = 4,
    parameter int ADDR_W    = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)
(
    input  logic [ADDR_W-1:0]      addr,
    output logic                   hit_slot,
    output logic [SLOT_W-1:0]      slot_sel,
    output logic [DWORD_SEL_W-1:0] dword_sel
);
    localparam int WIN_W     = $clog2(NUM_SLOTS) + 1;
    localparam int WIN_BYTES = (2 ** WIN_W) * (2 ** STRIDE_LOG2);
    localparam logic [ADDR_W-1:0] BASE_V   = ADDR_W'(ARRAY_PTR * 256);
    localparam logic [ADDR_W:0]   WIN_V    = (ADDR_W + 1)'(WIN_BYTES);
    localparam logic [WIN_W-1:0]  NSLOTS_V = WIN_W'(NUM_SLOTS);
    localparam logic [4:0]        NWORDS_V = 5'(SLOT_WORDS);

    logic [ADDR_W-1:0] a;
    logic [ADDR_W-1:0] off;
    logic [WIN_W-1:0]  win_slot;
    logic              in_win;

    // Locate the address inside the slot window and split it into slot and word.
    always_comb begin
        a         = addr & ~ADDR_W'(3);
        off       = a - BASE_V;
        in_win    = (a >= BASE_V) && ({1'b0, off} < WIN_V);
        win_slot  = WIN_W'(off >> STRIDE_LOG2);
        dword_sel = DWORD_SEL_W'(off >> 2);
        slot_sel  = SLOT_W'(win_slot);
        hit_slot  = in_win && (win_slot < NSLOTS_V) && (dword_sel < NWORDS_V);
    end
endmodule

// File: rtl/keyslot_entry.sv
// One keyslot: key words, control word, spare word and a programming-order tracker.
// The slot commits (turns valid) only when the enabling control write follows the
// full ordered sequence and carries well-formed fields. Assumes one write per cycle.
module keyslot_entry
    import keyslot_pkg::*;
#(
    parameter int NUM_CAPS = 4
)
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [DWORD_SEL_W-1:0] wr_dword,
    input  logic [DW-1:0]          wr_data,
    input  logic [DWORD_SEL_W-1:0] rd_dword,
    output logic [DW-1:0]          rd_word,
    output logic                   cfg_valid,
    output logic [KEY_BITS-1:0]    key_flat,
    output logic [7:0]             unit_mask,
    output logic [7:0]             cap_idx
);
    localparam logic [8:0] NCAP_V = 9'(NUM_CAPS);

    logic [DW-1:0]          key_q [KEY_WORDS];
    logic [DW-1:0]          ctrl_q;
    logic [DW-1:0]          spare_q;
    logic                   armed_q;
    logic [DWORD_SEL_W-1:0] next_q;
    logic                   valid_q;

    logic [7:0] wr_unit;
    logic [7:0] wr_cap;
    logic       fields_ok;

    // Judge whether the incoming control fields describe a usable configuration.
    always_comb begin
        wr_unit   = wr_data[7:0];
        wr_cap    = wr_data[15:8];
        fields_ok = ($countones(wr_unit) == 1) && ({1'b0, wr_cap} < NCAP_V)
                    && ((wr_unit & cap_unit_mask(wr_cap)) != 8'h00);
    end

    // Store words and advance the ordered-programming tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < KEY_WORDS; k++) key_q[k] <= '0;
            ctrl_q  <= '0;
            spare_q <= '0;
            armed_q <= 1'b0;
            next_q  <= '0;
            valid_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_dword == CTRL_DWORD) begin
                ctrl_q <= wr_data;
                if (!wr_data[EN_BIT]) begin
                    for (int k = 0; k < KEY_WORDS; k++) key_q[k] <= '0;
                    armed_q <= 1'b1;
                    next_q  <= '0;
                    valid_q <= 1'b0;
                end else begin
                    valid_q <= armed_q && (next_q == SPARE_DWORD) && fields_ok;
                    armed_q <= 1'b0;
                end
            end else if (!ctrl_q[EN_BIT]) begin
                if (wr_dword < CTRL_DWORD) begin
                    key_q[wr_dword[3:0]] <= wr_data;
                    if (armed_q && (next_q == wr_dword)) next_q <= next_q + 5'd1;
                    else armed_q <= 1'b0;
                end else if (wr_dword == SPARE_DWORD) begin
                    spare_q <= wr_data;
                    if (armed_q && (next_q == CTRL_DWORD)) next_q <= SPARE_DWORD;
                    else armed_q <= 1'b0;
                end
            end
        end
    end

    // Return the addressed word of this slot.
    always_comb begin
        if (rd_dword < CTRL_DWORD)        rd_word = key_q[rd_dword[3:0]];
        else if (rd_dword == CTRL_DWORD)  rd_word = ctrl_q;
        else if (rd_dword == SPARE_DWORD) rd_word = spare_q;
        else                              rd_word = '0;
    end

    // Flatten the key and expose the control fields.
    always_comb begin
        for (int k = 0; k < KEY_WORDS; k++) key_flat[DW*k +: DW] = key_q[k];
        unit_mask = ctrl_q[7:0];
        cap_idx   = ctrl_q[15:8];
        cfg_valid = valid_q;
    end

    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(wr_en && (wr_dword == CTRL_DWORD) && wr_data[EN_BIT]));

    // R6
    locked_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[EN_BIT] && wr_en && (wr_dword != CTRL_DWORD))
        |=> ($stable(key_flat) && $stable(spare_q) && $stable(valid_q)));

    // R9
    disable_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_dword == CTRL_DWORD) && !wr_data[EN_BIT])
        |=> ((key_flat == '0) && !valid_q));

    // R8
    valid_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (($countones(ctrl_q[7:0]) == 1) && ({1'b0, ctrl_q[15:8]} < NCAP_V)
                     && ctrl_q[EN_BIT]));
endmodule

// File: rtl/inline_keyslot_regs.sv
// Register file for the keyslots of an inline encryption engine.
// Holds a read-only capability word at 0x100, capability entries from 0x104, and
// NUM_SLOTS slot entries at ARRAY_PTR*0x100 on a 0x80 stride. Reads are registered.
// Assumes ARRAY_PTR >= 2 so the slot window clears the capability area.
module inline_keyslot_regs
    import keyslot_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_CAPS  = 4,
    parameter int ARRAY_PTR = 4,
    parameter int ADDR_W    = 16,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DW-1:0]         rd_data,
    output logic [NUM_SLOTS-1:0]  slot_valid,
    input  logic [SLOT_W-1:0]     dp_slot,
    output logic                  dp_valid,
    output logic [KEY_BITS-1:0]   dp_key,
    output logic [7:0]            dp_unit_mask,
    output logic [7:0]            dp_cap_idx
);
    localparam logic [DW-1:0]     CAP_REG_VAL = {8'(ARRAY_PTR), 8'h00, 8'(NUM_SLOTS - 1), 8'(NUM_CAPS)};
    localparam logic [ADDR_W-1:0] CAP_REG_A   = ADDR_W'(16'h0100);
    localparam logic [ADDR_W-1:0] CAP_ENT_A   = ADDR_W'(16'h0104);
    localparam logic [ADDR_W-1:0] CAP_SPAN    = ADDR_W'(4 * NUM_CAPS);

    logic                   w_hit, r_hit;
    logic [SLOT_W-1:0]      w_slot, r_slot;
    logic [DWORD_SEL_W-1:0] w_dword, r_dword;

    logic [DW-1:0]       rword_all  [NUM_SLOTS];
    logic [KEY_BITS-1:0] key_all    [NUM_SLOTS];
    logic [7:0]          unit_all   [NUM_SLOTS];
    logic [7:0]          cap_all    [NUM_SLOTS];

    logic [ADDR_W-1:0] ra;
    logic [ADDR_W-1:0] coff;
    logic              r_cap_reg, r_cap_ent;
    logic [DW-1:0]     rd_next;

    keyslot_addr_decode #(.NUM_SLOTS(NUM_SLOTS), .ARRAY_PTR(ARRAY_PTR), .ADDR_W(ADDR_W)) wdec_i (
        .addr(wr_addr), .hit_slot(w_hit), .slot_sel(w_slot), .dword_sel(w_dword));

    keyslot_addr_decode #(.NUM_SLOTS(NUM_SLOTS), .ARRAY_PTR(ARRAY_PTR), .ADDR_W(ADDR_W)) rdec_i (
        .addr(rd_addr), .hit_slot(r_hit), .slot_sel(r_slot), .dword_sel(r_dword));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic slot_we;
        // Route a decoded write to this slot only.
        always_comb slot_we = wr_en && w_hit && (w_slot == SLOT_W'(s));

        keyslot_entry #(.NUM_CAPS(NUM_CAPS)) slot_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(slot_we), .wr_dword(w_dword), .wr_data(wr_data),
            .rd_dword(r_dword), .rd_word(rword_all[s]),
            .cfg_valid(slot_valid[s]), .key_flat(key_all[s]),
            .unit_mask(unit_all[s]), .cap_idx(cap_all[s]));
    end

    // Decode the capability area and pick the read word.
    always_comb begin
        ra        = rd_addr & ~ADDR_W'(3);
        coff      = ra - CAP_ENT_A;
        r_cap_reg = (ra == CAP_REG_A);
        r_cap_ent = (ra >= CAP_ENT_A) && (coff < CAP_SPAN);
        rd_next   = '0;
        if (r_cap_reg)      rd_next = CAP_REG_VAL;
        else if (r_cap_ent) rd_next = cap_entry(8'(coff >> 2));
        else if (r_hit) begin
            for (int s = 0; s < NUM_SLOTS; s++)
                if (r_slot == SLOT_W'(s)) rd_next = rword_all[s];
        end
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    // Present the chosen slot to the datapath only when it is committed.
    always_comb begin
        dp_valid     = 1'b0;
        dp_key       = '0;
        dp_unit_mask = '0;
        dp_cap_idx   = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if ((dp_slot == SLOT_W'(s)) && slot_valid[s]) begin
                dp_valid     = 1'b1;
                dp_key       = key_all[s];
                dp_unit_mask = unit_all[s];
                dp_cap_idx   = cap_all[s];
            end
        end
    end

    // R11
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !r_hit && !r_cap_reg && !r_cap_ent) |=> (rd_data == '0));
endmodule

// File: tb/inline_keyslot_regs_tb.sv
module inline_keyslot_regs_tb_top;
    localparam int NS = 4;
    localparam int NC = 3;
    localparam int PTR = 2;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NS-1:0] slot_valid;
    logic [1:0]    dp_slot = '0;
    logic          dp_valid;
    logic [511:0]  dp_key;
    logic [7:0]    dp_unit_mask;
    logic [7:0]    dp_cap_idx;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [NS-1:0] exp_v;

    always #10 clk = ~clk;

    inline_keyslot_regs #(.NUM_SLOTS(NS), .NUM_CAPS(NC), .ARRAY_PTR(PTR), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .slot_valid(slot_valid),
        .dp_slot(dp_slot), .dp_valid(dp_valid), .dp_key(dp_key),
        .dp_unit_mask(dp_unit_mask), .dp_cap_idx(dp_cap_idx));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] sa(input int s, input int d);
        return 16'(PTR * 256 + s * 128 + d * 4);
    endfunction

    function automatic logic [31:0] kv(input int s, input int k, input int seed);
        return 32'h0A0B_0000 + 32'(seed) * 32'h0100_0000 + 32'(s) * 32'h100 + 32'(k);
    endfunction

    function automatic logic [31:0] xv(input int s, input int seed);
        return 32'h7700_0000 + 32'(seed) * 32'h10 + 32'(s);
    endfunction

    function automatic logic [31:0] mk(input int cap, input logic [7:0] mask);
        return 32'h8000_0000 | (32'(cap) << 8) | {24'd0, mask};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic prog(input int s, input int seed, input logic [31:0] ctrl);
        wr(sa(s, 16), 32'h0);
        for (int k = 0; k < 16; k++) wr(sa(s, k), kv(s, k, seed));
        wr(sa(s, 17), xv(s, seed));
        wr(sa(s, 16), ctrl);
    endtask

    task automatic dp_chk(input string req, input int s, input bit v, input int seed,
                          input logic [7:0] mask, input logic [7:0] cap);
        dp_slot = 2'(s);
        #1;
        chk({req, " dp_valid"}, {31'd0, dp_valid}, {31'd0, v});
        chk({req, " dp_unit_mask"}, {24'd0, dp_unit_mask}, v ? {24'd0, mask} : 32'd0);
        chk({req, " dp_cap_idx"}, {24'd0, dp_cap_idx}, v ? {24'd0, cap} : 32'd0);
        for (int k = 0; k < 16; k++)
            chk({req, " dp_key"}, dp_key[32*k +: 32], v ? kv(s, k, seed) : 32'd0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 slot_valid after reset", {28'd0, slot_valid}, 32'd0);
        for (int s = 0; s < NS; s++)
            for (int d = 0; d < 18; d++) rd_chk("R1 slot word after reset", sa(s, d), 32'd0);

        // R2 capability word and its immunity to writes
        rd_chk("R2 capability word", 16'h0100, {8'(PTR), 8'h00, 8'(NS - 1), 8'(NC)});
        wr(16'h0100, 32'hFFFF_FFFF);
        rd_chk("R2 capability word after write", 16'h0100, {8'(PTR), 8'h00, 8'(NS - 1), 8'(NC)});

        // R3 capability entries and the end of the array
        for (int i = 0; i < NC; i++)
            rd_chk("R3 capability entry", 16'(16'h0104 + 4 * i),
                   {8'h00, 8'h03, 8'hFF >> i, 8'(i + 1)});
        rd_chk("R3 past last entry", 16'(16'h0104 + 4 * NC), 32'd0);

        // R5 R4 ordered programming of every slot, then readback and lookup
        exp_v = '0;
        for (int s = 0; s < NS; s++) begin
            prog(s, 0, mk(s % NC, 8'(1 << s)));
            exp_v[s] = 1'b1;
            chk("R5 slot_valid after ordered program", {28'd0, slot_valid}, {28'd0, exp_v});
        end
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < 16; k++) rd_chk("R4 key readback", sa(s, k), kv(s, k, 0));
            rd_chk("R4 control readback", sa(s, 16), mk(s % NC, 8'(1 << s)));
            rd_chk("R4 spare readback", sa(s, 17), xv(s, 0));
            dp_chk("R5 lookup", s, 1'b1, 0, 8'(1 << s), 8'(s % NC));
        end
        rd_chk("R4 low address bits ignored", sa(2, 5) | 16'h3, kv(2, 5, 0));

        // R6 writes to an enabled slot are ignored
        wr(sa(0, 3), 32'hDEAD_BEEF);
        wr(sa(0, 17), 32'h1234_5678);
        rd_chk("R6 key word kept", sa(0, 3), kv(0, 3, 0));
        rd_chk("R6 spare word kept", sa(0, 17), xv(0, 0));
        chk("R6 slot_valid unchanged", {28'd0, slot_valid}, {28'd0, exp_v});

        // R10 re-enable without a fresh sequence
        wr(sa(0, 16), mk(0, 8'h01));
        exp_v[0] = 1'b0;
        chk("R10 re-enable drops valid", {28'd0, slot_valid}, {28'd0, exp_v});
        rd_chk("R10 control stored", sa(0, 16), mk(0, 8'h01));
        dp_chk("R10 lookup", 0, 1'b0, 0, 8'h00, 8'h00);

        // R7 swapped key words
        wr(sa(1, 16), 32'h0);
        exp_v[1] = 1'b0;
        wr(sa(1, 0), kv(1, 0, 2));
        wr(sa(1, 2), kv(1, 2, 2));
        wr(sa(1, 1), kv(1, 1, 2));
        for (int k = 3; k < 16; k++) wr(sa(1, k), kv(1, k, 2));
        wr(sa(1, 17), xv(1, 2));
        wr(sa(1, 16), mk(1, 8'h02));
        chk("R7 swapped keys stay invalid", {28'd0, slot_valid}, {28'd0, exp_v});
        rd_chk("R7 swapped key stored", sa(1, 1), kv(1, 1, 2));
        prog(1, 3, mk(1, 8'h02));
        exp_v[1] = 1'b1;
        chk("R7 reprogram recovers", {28'd0, slot_valid}, {28'd0, exp_v});
        dp_chk("R7 recovered lookup", 1, 1'b1, 3, 8'h02, 8'h01);

        // R7 spare word skipped
        wr(sa(2, 16), 32'h0);
        for (int k = 0; k < 16; k++) wr(sa(2, k), kv(2, k, 4));
        wr(sa(2, 16), mk(2, 8'h04));
        exp_v[2] = 1'b0;
        chk("R7 skipped spare stays invalid", {28'd0, slot_valid}, {28'd0, exp_v});

        // R8 malformed control fields
        prog(3, 5, mk(0, 8'h03));
        exp_v[3] = 1'b0;
        chk("R8 two-bit unit mask", {28'd0, slot_valid}, {28'd0, exp_v});
        prog(3, 5, mk(0, 8'h00));
        chk("R8 empty unit mask", {28'd0, slot_valid}, {28'd0, exp_v});
        prog(3, 5, mk(NC, 8'h01));
        chk("R8 capability index out of range", {28'd0, slot_valid}, {28'd0, exp_v});
        rd_chk("R8 bad control stored", sa(3, 16), mk(NC, 8'h01));
        prog(3, 5, mk(2, 8'h80));
        chk("R8 mask outside capability", {28'd0, slot_valid}, {28'd0, exp_v});
        prog(3, 6, mk(0, 8'h80));
        exp_v[3] = 1'b1;
        chk("R8 65536-byte boundary accepted", {28'd0, slot_valid}, {28'd0, exp_v});
        dp_chk("R8 boundary lookup", 3, 1'b1, 6, 8'h80, 8'h00);

        // R9 eviction by zeroing every word in ascending order
        for (int d = 0; d < 18; d++) wr(sa(3, d), 32'h0);
        exp_v[3] = 1'b0;
        chk("R9 evicted slot invalid", {28'd0, slot_valid}, {28'd0, exp_v});
        for (int d = 0; d < 18; d++) rd_chk("R9 evicted word zero", sa(3, d), 32'd0);
        dp_chk("R9 evicted lookup", 3, 1'b0, 0, 8'h00, 8'h00);

        // R9 disable alone wipes the key
        wr(sa(1, 16), 32'h0000_0102);
        exp_v[1] = 1'b0;
        chk("R9 disable drops valid", {28'd0, slot_valid}, {28'd0, exp_v});
        rd_chk("R9 disable wipes key", sa(1, 5), 32'd0);

        // R11 out-of-range slots, reserved words, unmapped addresses
        wr(sa(7, 5), 32'hCAFE_0007);
        rd_chk("R11 high slot read zero", sa(7, 5), 32'd0);
        rd_chk("R11 high slot no alias", sa(3, 5), 32'd0);
        wr(sa(4, 16), mk(0, 8'h01));
        chk("R11 high slot control dropped", {28'd0, slot_valid}, {28'd0, exp_v});
        rd_chk("R11 high slot control no alias", sa(0, 16), mk(0, 8'h01));
        wr(16'(PTR * 256 + 8 * 128 + 3 * 128), 32'hBEEF_0008);
        rd_chk("R11 past window no alias", sa(3, 0), 32'd0);
        wr(sa(3, 18), 32'h0000_0055);
        rd_chk("R11 reserved word zero", sa(3, 18), 32'd0);
        rd_chk("R11 unmapped zero", 16'h0080, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule